// File: doc/BRIEF.md
# Cartridge Bank Register Decoder

This block watches the CPU write bus of a game-cartridge memory mapper. It decodes writes in the upper half of the CPU address space into a small register set. The set holds two program bank numbers, eight character bank numbers, a nametable mirroring code and a window-swap bit. Six alternate address lines are merged onto the two register-select lines before decoding. Boards that route their register selects to different address pins therefore all reach the same registers.

From these registers the block drives bank numbers for four 8 KB program windows and eight 1 KB character windows, all as combinational outputs. It also forms full physical program and character addresses for the current CPU and video addresses. Every program bank is ORed with a fixed outer-bank value. A strap input selects a second board variant. In that variant a single write loads both program registers as an even/odd pair, and the direct load of the first program register is not decoded.

Top module: `cart_bank_decoder`

## Requirements
- R1: After a synchronous active-low reset, every bank register is zero. The program windows at 0x8000, 0xA000, 0xC000 and 0xE000 then read 0x20, 0x20, 0x3E and 0x3F, all character banks read 0, and the mirroring code reads 0.
- R2: Before decoding, the select code is address bits [1:0] ORed with bits [3:2], [5:4] and [7:6]. Address bits [11:8] are ignored. For example, 0xB008 selects character register 1, low nibble; 0x9004 selects mirroring; 0x9080 selects the swap bit.
- R3: With the strap low, a write to page 0x8 (0x8000–0x8FFF after folding) loads program register A with data[4:0]. With the strap high, such a write leaves every register unchanged.
- R4: With the strap low, a write to page 0xA loads program register B with data[4:0]. With the strap high, it loads register A with {data[3:0],0} and register B with {data[3:0],1}.
- R5: A write to pages 0xB–0xE targets character register 2*(page−0xB)+select[1]. Select bit 0 clear replaces bits [3:0] with data[3:0]. Select bit 0 set replaces bits [7:4] with data[3:0]. The other nibble and the other registers keep their values.
- R6: A write to page 0x9 with select bit 1 clear loads the mirroring code with data[1:0], unless the data byte is 0xFF. In that case the code keeps its value. The codes are 0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper.
- R7: A write to page 0x9 with select bit 1 set loads the swap bit from data[1]. When swap is clear, the 0x8000 window uses register A and the 0xC000 window uses bank 0x1E. When swap is set, these two exchange.
- R8: The 0xA000 window always uses register B, and the 0xE000 window always uses bank 0x1F. Every program window value is ORed with the outer bank 0x20.
- R9: Nothing changes when the write strobe is low, when the address is below 0x8000, or when the page is 0xF.
- R10: The program physical address is {window bank selected by cpu_addr[14:13], cpu_addr[12:0]}. The character physical address is {character bank selected by ppu_addr[12:10], ppu_addr[9:0]}.

Bank values are exposed on packed buses: window w of `prg_bank` is bits [6w+5:6w], and character register i of `chr_bank` is bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_variant | input | 1 | Strap: 1 selects the paired program-bank variant |
| wr_en | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| wr_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Video pattern address |
| prg_bank | output | 24 | Four 6-bit program window banks |
| chr_bank | output | 64 | Eight 8-bit character banks |
| mirror_mode | output | 2 | Nametable mirroring code |
| prg_phys_addr | output | 19 | Physical program address |
| chr_phys_addr | output | 18 | Physical character address |

## Verification
Several properties are checked on every cycle:
- Idle cycles, writes below 0x8000 and page-0xF writes leave all state untouched.
- A 0xFF mirroring write holds the code.
- A nibble write keeps the opposite nibble.
- In the strap-high variant, a page-0x8 write is dropped and a page-0xA write leaves the B register odd and one above A.
- One of the two swappable windows always carries the fixed second-to-last bank.

Only the bench's scenarios can show that folded addresses land on the intended register, that the exact bank values and physical addresses are correct, and that the reset values are right. The bench shows these by comparing every output against a behavioural model on every clock.

// File: rtl/cbd_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and decode types for the cartridge bank decoder.
// Assumes a 16-bit CPU address and an 8-bit data bus.
package cbd_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PAGE_W     = 4;
    localparam int FOLD_PAIRS = 3;
    localparam int LOW_W      = 2 * (FOLD_PAIRS + 1);
    localparam int PRG_REG_W  = 5;
    localparam int NIB_W      = 4;
    localparam int CHR_IDX_W  = 3;
    localparam int CHR_REGS   = 1 << CHR_IDX_W;
    localparam int PRG_WIN_W  = 13;
    localparam int CHR_WIN_W  = 10;
    localparam int PRG_WINDOWS = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PRG_A,
        SEL_PRG_B,
        SEL_MIRROR,
        SEL_SWAP,
        SEL_CHR
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e               sel;
        logic [CHR_IDX_W-1:0]   chr_idx;
        logic                   hi_nib;
    } wr_decode_t;
endpackage

// File: rtl/cbd_addr_fold.sv
`timescale 1ns/1ps
// Module: cbd_addr_fold
// Merges the alternate select pairs onto the two select bits and turns a
// qualified write into a register selection. Purely combinational.
// Assumes the page is cpu_addr[15:12]; pages below 0x8 and page 0xF decode
// to no register.
module cbd_addr_fold import cbd_pkg::*; (
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] page,
    input  logic [LOW_W-1:0]  low_bits,
    output wr_decode_t        dec
);
    logic [1:0] fold_sel;

    // Fold: OR every alternate address pair onto the primary select pair.
    always_comb begin
        fold_sel = low_bits[1:0];
        for (int k = 1; k <= FOLD_PAIRS; k++) begin
            fold_sel = fold_sel | low_bits[2*k +: 2];
        end
    end

    // Decode: map the page and the folded select to a register target.
    always_comb begin
        dec.sel     = SEL_NONE;
        dec.chr_idx = '0;
        dec.hi_nib  = fold_sel[0];
        if (wr_en) begin
            case (page)
                4'h8: dec.sel = SEL_PRG_A;
                4'h9: dec.sel = fold_sel[1] ? SEL_SWAP : SEL_MIRROR;
                4'hA: dec.sel = SEL_PRG_B;
                4'hB: begin dec.sel = SEL_CHR; dec.chr_idx = {2'd0, fold_sel[1]}; end
                4'hC: begin dec.sel = SEL_CHR; dec.chr_idx = {2'd1, fold_sel[1]}; end
                4'hD: begin dec.sel = SEL_CHR; dec.chr_idx = {2'd2, fold_sel[1]}; end
                4'hE: begin dec.sel = SEL_CHR; dec.chr_idx = {2'd3, fold_sel[1]}; end
                default: dec.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cbd_reg_file.sv
`timescale 1ns/1ps
// Module: cbd_reg_file
// Holds the program, character, mirroring and swap registers and applies
// decoded writes. The strap selects the paired program-bank variant.
// Assumes the strap is static while out of reset.
module cbd_reg_file import cbd_pkg::*; #(
    parameter int CHR_BANK_W = 2 * NIB_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 alt_variant,
    input  wr_decode_t                           dec,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [PRG_REG_W-1:0]                 prg_a_q,
    output logic [PRG_REG_W-1:0]                 prg_b_q,
    output logic [1:0]                           mirror_q,
    output logic                                 swap_q,
    output logic [CHR_REGS-1:0][CHR_BANK_W-1:0]  chr_q
);
    localparam int HI_LSB = CHR_BANK_W - NIB_W;

    // Program registers: direct loads, or the even/odd pair in the alternate variant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg_a_q <= '0;
            prg_b_q <= '0;
        end else if (dec.sel == SEL_PRG_A && !alt_variant) begin
            prg_a_q <= wr_data[PRG_REG_W-1:0];
        end else if (dec.sel == SEL_PRG_B) begin
            if (alt_variant) begin
                prg_a_q <= {wr_data[PRG_REG_W-2:0], 1'b0};
                prg_b_q <= {wr_data[PRG_REG_W-2:0], 1'b1};
            end else begin
                prg_b_q <= wr_data[PRG_REG_W-1:0];
            end
        end
    end

    // Mirroring code: loads unless the data byte is all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mirror_q <= '0;
        end else if (dec.sel == SEL_MIRROR && wr_data != '1) begin
            mirror_q <= wr_data[1:0];
        end
    end

    // Swap bit: taken from data bit 1 on a swap-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_q <= 1'b0;
        end else if (dec.sel == SEL_SWAP) begin
            swap_q <= wr_data[1];
        end
    end

    // Character registers: one per index, written a nibble at a time.
    for (genvar g = 0; g < CHR_REGS; g++) begin : g_chr
        logic [CHR_BANK_W-1:0] bank_r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_r <= '0;
            end else if (dec.sel == SEL_CHR && dec.chr_idx == CHR_IDX_W'(g)) begin
                if (dec.hi_nib) bank_r[CHR_BANK_W-1:HI_LSB] <= wr_data[NIB_W-1:0];
                else            bank_r[NIB_W-1:0]           <= wr_data[NIB_W-1:0];
            end
        end
        assign chr_q[g] = bank_r;
    end

    AST_ALT_PRG_A_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_variant && dec.sel == SEL_PRG_A) |=> $stable(prg_a_q) && $stable(prg_b_q)); // R3
    AST_PRG_A_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_variant && dec.sel == SEL_PRG_A) |=> prg_a_q == $past(wr_data[PRG_REG_W-1:0])); // R3
    AST_ALT_PAIR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_variant && dec.sel == SEL_PRG_B) |=> prg_b_q == (prg_a_q | PRG_REG_W'(1))); // R4
    AST_MIRROR_FF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.sel == SEL_MIRROR && wr_data == '1) |=> $stable(mirror_q)); // R6
    AST_LOW_NIB_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.sel == SEL_CHR && !dec.hi_nib) |=>
        chr_q[$past(dec.chr_idx)][CHR_BANK_W-1:HI_LSB] == $past(chr_q[dec.chr_idx][CHR_BANK_W-1:HI_LSB])); // R5
    AST_HIGH_NIB_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.sel == SEL_CHR && dec.hi_nib) |=>
        chr_q[$past(dec.chr_idx)][NIB_W-1:0] == $past(chr_q[dec.chr_idx][NIB_W-1:0])); // R5
    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.sel == SEL_NONE) |=> $stable(prg_a_q) && $stable(prg_b_q) && $stable(chr_q)
        && $stable(mirror_q) && $stable(swap_q)); // R9
endmodule

// File: rtl/cbd_bank_map.sv
`timescale 1ns/1ps
// Module: cbd_bank_map
// Builds the four program window banks (with fixed banks, swap and outer
// bank) and the physical program and character addresses. Combinational.
// Assumes the window index is cpu_addr[14:13] and the character register
// index is ppu_addr[12:10].
module cbd_bank_map import cbd_pkg::*; #(
    parameter int                  PRG_BANK_W = PRG_REG_W + 1,
    parameter logic [PRG_BANK_W-1:0] OUTER_BANK = PRG_BANK_W'(32),
    parameter int                  CHR_BANK_W = 2 * NIB_W
) (
    input  logic [PRG_REG_W-1:0]                   prg_a_q,
    input  logic [PRG_REG_W-1:0]                   prg_b_q,
    input  logic                                   swap_q,
    input  logic [CHR_REGS-1:0][CHR_BANK_W-1:0]    chr_q,
    input  logic [PRG_WIN_W+1:0]                   cpu_low,
    input  logic [CHR_IDX_W+CHR_WIN_W-1:0]         ppu_addr,
    output logic [PRG_WINDOWS-1:0][PRG_BANK_W-1:0] win_bank,
    output logic [PRG_BANK_W+PRG_WIN_W-1:0]        prg_phys,
    output logic [CHR_BANK_W+CHR_WIN_W-1:0]        chr_phys
);
    localparam logic [PRG_REG_W-1:0] FIX_LAST = '1;
    localparam logic [PRG_REG_W-1:0] FIX_PEN  = FIX_LAST - 1'b1;

    logic [PRG_BANK_W-1:0] a_ext, b_ext, last_ext, pen_ext;

    // Extend the register and fixed banks and merge the outer bank.
    always_comb begin
        a_ext    = PRG_BANK_W'(prg_a_q)  | OUTER_BANK;
        b_ext    = PRG_BANK_W'(prg_b_q)  | OUTER_BANK;
        last_ext = PRG_BANK_W'(FIX_LAST) | OUTER_BANK;
        pen_ext  = PRG_BANK_W'(FIX_PEN)  | OUTER_BANK;
    end

    // Each window picks its source; windows 0 and 2 exchange under swap.
    for (genvar w = 0; w < PRG_WINDOWS; w++) begin : g_win
        if (w == 0) begin : g_first
            assign win_bank[w] = swap_q ? pen_ext : a_ext;
        end else if (w == 1) begin : g_second
            assign win_bank[w] = b_ext;
        end else if (w == 2) begin : g_third
            assign win_bank[w] = swap_q ? a_ext : pen_ext;
        end else begin : g_last
            assign win_bank[w] = last_ext;
        end
    end

    // Physical addresses: selected bank on top of the in-window offset.
    always_comb begin
        prg_phys = {win_bank[cpu_low[PRG_WIN_W+1:PRG_WIN_W]], cpu_low[PRG_WIN_W-1:0]};
        chr_phys = {chr_q[ppu_addr[CHR_IDX_W+CHR_WIN_W-1:CHR_WIN_W]], ppu_addr[CHR_WIN_W-1:0]};
    end
endmodule

// File: rtl/cart_bank_decoder.sv
`timescale 1ns/1ps
// Module: cart_bank_decoder (top)
// Decodes CPU writes into mapper bank registers and drives program and
// character bank numbers, mirroring code and physical addresses.
// Assumes a synchronous active-low reset and a static variant strap.
module cart_bank_decoder import cbd_pkg::*; #(
    parameter int                    PRG_BANK_W = PRG_REG_W + 1,
    parameter logic [PRG_BANK_W-1:0] OUTER_BANK = PRG_BANK_W'(32),
    parameter int                    CHR_BANK_W = 2 * NIB_W,
    localparam int PRG_BUS_W  = PRG_WINDOWS * PRG_BANK_W,
    localparam int CHR_BUS_W  = CHR_REGS * CHR_BANK_W,
    localparam int PPU_W      = CHR_IDX_W + CHR_WIN_W,
    localparam int PRG_PHYS_W = PRG_BANK_W + PRG_WIN_W,
    localparam int CHR_PHYS_W = CHR_BANK_W + CHR_WIN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alt_variant,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [PPU_W-1:0]      ppu_addr,
    output logic [PRG_BUS_W-1:0]  prg_bank,
    output logic [CHR_BUS_W-1:0]  chr_bank,
    output logic [1:0]            mirror_mode,
    output logic [PRG_PHYS_W-1:0] prg_phys_addr,
    output logic [CHR_PHYS_W-1:0] chr_phys_addr
);
    localparam logic [PRG_BANK_W-1:0] PEN_EXT =
        PRG_BANK_W'((1 << PRG_REG_W) - 2) | OUTER_BANK;

    wr_decode_t                             dec;
    logic [PRG_REG_W-1:0]                   prg_a_q, prg_b_q;
    logic                                   swap_q;
    logic [CHR_REGS-1:0][CHR_BANK_W-1:0]    chr_q;
    logic [PRG_WINDOWS-1:0][PRG_BANK_W-1:0] win_bank;

    cbd_addr_fold u_fold (
        .wr_en    (wr_en),
        .page     (cpu_addr[ADDR_W-1:ADDR_W-PAGE_W]),
        .low_bits (cpu_addr[LOW_W-1:0]),
        .dec      (dec)
    );

    cbd_reg_file #(.CHR_BANK_W(CHR_BANK_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .alt_variant (alt_variant),
        .dec         (dec),
        .wr_data     (wr_data),
        .prg_a_q     (prg_a_q),
        .prg_b_q     (prg_b_q),
        .mirror_q    (mirror_mode),
        .swap_q      (swap_q),
        .chr_q       (chr_q)
    );

    cbd_bank_map #(
        .PRG_BANK_W (PRG_BANK_W),
        .OUTER_BANK (OUTER_BANK),
        .CHR_BANK_W (CHR_BANK_W)
    ) u_map (
        .prg_a_q  (prg_a_q),
        .prg_b_q  (prg_b_q),
        .swap_q   (swap_q),
        .chr_q    (chr_q),
        .cpu_low  (cpu_addr[PRG_WIN_W+1:0]),
        .ppu_addr (ppu_addr),
        .win_bank (win_bank),
        .prg_phys (prg_phys_addr),
        .chr_phys (chr_phys_addr)
    );

    // Flatten the bank arrays onto the output buses.
    always_comb begin
        prg_bank = win_bank;
        chr_bank = chr_q;
    end

    AST_SWAP_KEEPS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (win_bank[0] == PEN_EXT) || (win_bank[2] == PEN_EXT)); // R7
    AST_LOW_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cpu_addr[ADDR_W-1]) |=> $stable(prg_bank) && $stable(chr_bank)
        && $stable(mirror_mode)); // R9
    AST_TOP_PAGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_addr[ADDR_W-1:ADDR_W-PAGE_W] == 4'hF) |=> $stable(prg_bank)
        && $stable(chr_bank) && $stable(mirror_mode)); // R9
endmodule

// File: tb/cart_bank_decoder_test.sv
`timescale 1ns/1ps
module cart_bank_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_variant = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  wr_data = 8'h00;
    logic [12:0] ppu_addr = 13'h0000;
    logic [23:0] prg_bank;
    logic [63:0] chr_bank;
    logic [1:0]  mirror_mode;
    logic [18:0] prg_phys_addr;
    logic [17:0] chr_phys_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    bit comparing = 0;

    // Behavioural model state
    int m_prg_a, m_prg_b, m_mirror, m_swap;
    int m_chr [8];
    bit m_alt;

    cart_bank_decoder uut (
        .clk(clk), .rst_n(rst_n), .alt_variant(alt_variant), .wr_en(wr_en),
        .cpu_addr(cpu_addr), .wr_data(wr_data), .ppu_addr(ppu_addr),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror_mode(mirror_mode),
        .prg_phys_addr(prg_phys_addr), .chr_phys_addr(chr_phys_addr)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_win(input int w);
        case (w)
            0: return m_swap ? 62 : (m_prg_a | 32);
            1: return m_prg_b | 32;
            2: return m_swap ? (m_prg_a | 32) : 62;
            default: return 63;
        endcase
    endfunction

    function automatic int win(input int w);
        return int'(prg_bank[w*6 +: 6]);
    endfunction

    function automatic int chr(input int i);
        return int'(chr_bank[i*8 +: 8]);
    endfunction

    function automatic void model_reset(input bit alt);
        m_prg_a = 0; m_prg_b = 0; m_mirror = 0; m_swap = 0; m_alt = alt;
        for (int i = 0; i < 8; i++) m_chr[i] = 0;
    endfunction

    function automatic void model_write(input int a, input int d);
        int sel, page, idx;
        sel  = (a & 3) | ((a >> 2) & 3) | ((a >> 4) & 3) | ((a >> 6) & 3);
        page = a / 4096;
        if (page == 8) begin
            if (!m_alt) m_prg_a = d % 32;
        end else if (page == 9) begin
            if (sel >= 2) m_swap = (d / 2) % 2;
            else if (d != 255) m_mirror = d % 4;
        end else if (page == 10) begin
            if (m_alt) begin
                m_prg_a = (d * 2) % 32;
                m_prg_b = m_prg_a + 1;
            end else begin
                m_prg_b = d % 32;
            end
        end else if (page >= 11 && page <= 14) begin
            idx = (page - 11) * 2 + (sel / 2);
            if (sel % 2 == 1) m_chr[idx] = (m_chr[idx] % 16) + (d % 16) * 16;
            else              m_chr[idx] = (m_chr[idx] / 16) * 16 + (d % 16);
        end
    endfunction

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (comparing && rst_n) begin
            for (int w = 0; w < 4; w++) chk("R8", "window bank", win(w), exp_win(w));
            for (int i = 0; i < 8; i++) chk("R5", "chr bank", chr(i), m_chr[i]);
            chk("R6", "mirror", int'(mirror_mode), m_mirror);
            chk("R10", "prg phys", int'(prg_phys_addr),
                exp_win(int'(cpu_addr[14:13])) * 8192 + int'(cpu_addr[12:0]));
            chk("R10", "chr phys", int'(chr_phys_addr),
                m_chr[int'(ppu_addr[12:10])] * 1024 + int'(ppu_addr[9:0]));
        end
    end

    task automatic do_reset(input bit alt);
        comparing = 0;
        #2;
        rst_n = 1'b0; wr_en = 1'b0; alt_variant = alt;
        model_reset(alt);
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        comparing = 1;
    endtask

    task automatic wr(input int a, input int d);
        #2;
        cpu_addr = a[15:0]; wr_data = d[7:0]; wr_en = 1'b1;
        @(posedge clk);
        #1;
        model_write(a, d);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int a, input int d);
        #2;
        cpu_addr = a[15:0]; wr_data = d[7:0]; wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r;
        int ab;
        do_reset(1'b0);
        #1;
        // R1 reset values
        chk("R1", "win0", win(0), 32'h20);
        chk("R1", "win1", win(1), 32'h20);
        chk("R1", "win2", win(2), 32'h3E);
        chk("R1", "win3", win(3), 32'h3F);
        chk("R1", "chr7", chr(7), 0);
        chk("R1", "mirror", int'(mirror_mode), 0);

        // R3 normal variant loads register A with data[4:0]
        wr(16'h8000, 8'h07); #1 chk("R3", "win0", win(0), 32'h27);
        wr(16'h8003, 8'hFF); #1 chk("R3", "win0 masked", win(0), 32'h3F);
        wr(16'h8002, 8'h04); #1 chk("R3", "win0", win(0), 32'h24);
        // R4 normal variant loads register B
        wr(16'hA001, 8'h0A); #1 chk("R4", "win1", win(1), 32'h2A);
        // R7 swap
        wr(16'h9002, 8'h02); #1;
        chk("R7", "win0 swapped", win(0), 32'h3E);
        chk("R7", "win2 swapped", win(2), 32'h24);
        chk("R8", "win1 unaffected", win(1), 32'h2A);
        chk("R8", "win3 fixed", win(3), 32'h3F);
        wr(16'h9003, 8'h01); #1;
        chk("R7", "win0 restored", win(0), 32'h24);
        chk("R7", "win2 restored", win(2), 32'h3E);
        // R6 mirroring and the 0xFF hold
        wr(16'h9000, 8'h01); #1 chk("R6", "mirror horiz", int'(mirror_mode), 1);
        wr(16'h9001, 8'hFF); #1 chk("R6", "mirror held on FF", int'(mirror_mode), 1);
        wr(16'h9000, 8'h06); #1 chk("R6", "mirror low bits", int'(mirror_mode), 2);
        // R5 nibble writes to all eight character registers
        for (int i = 0; i < 8; i++) begin
            ab = 16'hB000 + (i / 2) * 16'h1000 + (i % 2) * 2;
            wr(ab, 8'hF0 | i);
            wr(ab + 1, 8'h30 | (15 - i));
        end
        #1;
        for (int i = 0; i < 8; i++) chk("R5", "chr nibble pair", chr(i), (15 - i) * 16 + i);
        wr(16'hD002, 8'h09); #1 chk("R5", "chr5 low only", chr(5), 32'hA9);
        // R2 address folding
        wr(16'hB008, 8'h0C); #1 chk("R2", "chr1 via bit3", chr(1), 32'hEC);
        wr(16'h9004, 8'h03); #1;
        chk("R2", "mirror via bit2", int'(mirror_mode), 3);
        chr_check_swap: chk("R2", "swap untouched", win(0), 32'h24);
        wr(16'h9080, 8'h02); #1 chk("R2", "swap via bit7", win(0), 32'h3E);
        wr(16'h90C0, 8'h00); #1 chk("R2", "swap clear via bits7:6", win(0), 32'h24);
        wr(16'h9F00, 8'h01); #1 chk("R2", "bits11:8 ignored", int'(mirror_mode), 1);
        // R9 ignored writes
        idle(16'h8000, 8'h11);
        wr(16'h7000, 8'h13);
        wr(16'h0003, 8'h00);
        wr(16'hF002, 8'h05);
        wr(16'hF000, 8'h0F);
        #1;
        chk("R9", "win0 kept", win(0), 32'h24);
        chk("R9", "mirror kept", int'(mirror_mode), 1);
        chk("R9", "chr0 kept", chr(0), 32'hF0);
        // R10 physical addresses
        idle(16'hA123, 8'h00);
        #2 ppu_addr = 13'h16AB;
        #1;
        chk("R10", "prg phys A123", int'(prg_phys_addr), 32'h2A * 8192 + 32'h123);
        chk("R10", "chr phys", int'(chr_phys_addr), 32'hA9 * 1024 + 32'h2AB);
        #2 cpu_addr = 16'hE1FF;
        #1 chk("R10", "prg phys E1FF", int'(prg_phys_addr), 32'h3F * 8192 + 32'h1FF);
        @(negedge clk);

        // Alternate variant
        do_reset(1'b1);
        wr(16'h8000, 8'h05); #1 chk("R3", "alt ignores page 8", win(0), 32'h20);
        wr(16'hA000, 8'h0B); #1;
        chk("R4", "alt pair A", win(0), 32'h36);
        chk("R4", "alt pair B", win(1), 32'h37);
        wr(16'hA002, 8'h1F); #1;
        chk("R4", "alt pair A wrap", win(0), 32'h3E);
        chk("R4", "alt pair B wrap", win(1), 32'h3F);

        // Pseudo-random traffic in both variants, checked every clock
        r = 32'h1234_5678;
        for (int v = 0; v < 2; v++) begin
            do_reset(v[0]);
            for (int n = 0; n < 300; n++) begin
                r = r ^ (r << 13); r = r ^ (r >>> 17); r = r ^ (r << 5);
                #2 ppu_addr = r[28:16];
                if (r[3:0] == 4'h0) wr((r >> 8) & 16'h7FFF, r & 255);
                else if (r[3:0] == 4'h1) idle(16'h8000 | ((r >> 8) & 16'h7FFF), r & 255);
                else if (r[3:0] == 4'h2) wr(16'h9000 | ((r >> 8) & 16'h0FFF), 255);
                else wr(16'h8000 | ((r >> 8) & 16'h7FFF), r & 255);
            end
        end

        comparing = 0;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule